// File: doc/BRIEF.md
# Dual Countdown Timer Pair

This block holds two 8-bit countdown registers for a small virtual machine. One paces program delays, and the other gates a tone. A divider derived from the system clock produces an enable pulse at 60 Hz. On every pulse, each register that holds a nonzero value steps down by one. A register that reaches zero stays there. The countdown runs by itself, whatever the rate at which the processor executes instructions.

The processor loads either register through a shared data bus, using one strobe per register. It reads the delay register back directly from an output port. The sound register is not readable. It is visible only through `sound_on`, which is high whenever that register holds a nonzero value. A load that falls in the same cycle as a tick wins, and the loaded value is kept as written.

Top module: `dual_countdown`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, both registers are cleared to 0, `sound_on` is low and the tick divider returns to its start. The first tick after reset falls at the DIV-th clock edge with `rst` low, where DIV = CLK_HZ / TICK_HZ.
- R2: The tick is a one-cycle pulse that repeats every DIV clock cycles. Two successive decrements of a register that is not being loaded are exactly DIV cycles apart.
- R3: At a tick, a register that holds a nonzero value and is not being loaded decreases by exactly one.
- R4: A register at 0 that is not being loaded stays at 0 through ticks and never wraps to 255.
- R5: `sound_on` is high exactly when the sound register is nonzero. It goes low at the tick that takes the sound register from 1 to 0.
- R6: A load strobe (`delay_wr` or `sound_wr`) stores `wr_value` into its register at that clock edge, even when a tick lands on the same edge. The stored value is not decremented at that edge.
- R7: A load of one register leaves the other register unchanged. Between ticks, a register that is not being loaded holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| delay_wr | input | 1 | Load strobe for the delay register |
| sound_wr | input | 1 | Load strobe for the sound register |
| wr_value | input | 8 | Value to load |
| delay_value | output | 8 | Current delay register contents |
| sound_on | output | 1 | High while the sound register is nonzero |

## Verification
All results are registered. A load shows on `delay_value` or `sound_on` in the cycle after its clock edge. A decrement shows in the cycle after the tick edge, and that edge is the DIV-th one counted from reset release or from the previous tick. The bench keeps a cycle model of the divider and both registers. The model advances on each rising edge, and the bench drives the ports and compares them on the falling edge, so every comparison is made half a cycle after the edge that produced the result. Directed cases place a load exactly on a tick edge, measure the spacing between two decrements, and wait past several ticks with a register at zero.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int unsigned TMR_W      = 8;
    localparam int unsigned NUM_TIMERS = 2;

    typedef enum logic [0:0] {
        TMR_DELAY = 1'b0,
        TMR_SOUND = 1'b1
    } tmr_id_e;

    typedef struct packed {
        logic             en;
        logic [TMR_W-1:0] val;
    } tmr_load_t;

    function automatic int unsigned tick_divisor(input int unsigned clk_hz,
                                                 input int unsigned tick_hz);
        int unsigned d;
        d = clk_hz / tick_hz;
        return (d < 2) ? 2 : d;
    endfunction

endpackage

// File: rtl/cdt_tick_gen.sv
module cdt_tick_gen #(
    parameter int unsigned DIV = 833333
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || tick) cnt <= '0;
        else             cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter
    import cdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  tmr_load_t        load,
    output logic [TMR_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)                          count <= '0;
        else if (load.en)                 count <= load.val;
        else if (tick && (count != '0))   count <= count - TMR_W'(1);
    end
endmodule

// File: rtl/dual_countdown.sv
module dual_countdown
    import cdt_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned TICK_HZ = 60
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             delay_wr,
    input  logic             sound_wr,
    input  logic [TMR_W-1:0] wr_value,
    output logic [TMR_W-1:0] delay_value,
    output logic             sound_on
);
    localparam int unsigned DIV = tick_divisor(CLK_HZ, TICK_HZ);

    logic             tick_pulse;
    tmr_load_t        loads  [NUM_TIMERS];
    logic [TMR_W-1:0] counts [NUM_TIMERS];

    cdt_tick_gen #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick_pulse)
    );

    always_comb begin
        loads[TMR_DELAY] = '{en: delay_wr, val: wr_value};
        loads[TMR_SOUND] = '{en: sound_wr, val: wr_value};
    end

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
        cdt_counter u_cnt (
            .clk   (clk),
            .rst   (rst),
            .tick  (tick_pulse),
            .load  (loads[t]),
            .count (counts[t])
        );
    end

    assign delay_value = counts[TMR_DELAY];
    assign sound_on    = (counts[TMR_SOUND] != '0);
endmodule

// File: rtl/dual_countdown_chk.sv
module dual_countdown_chk (
    input logic       clk,
    input logic       rst,
    input logic       delay_wr,
    input logic       sound_wr,
    input logic [7:0] wr_value,
    input logic [7:0] delay_value,
    input logic       sound_on,
    input logic       tick
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (delay_value == 8'd0 && !sound_on));

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    a_r3_step_one: assert property (@(posedge clk) disable iff (rst)
        (!delay_wr && tick && delay_value != 8'd0) |=> delay_value == $past(delay_value) - 8'd1);

    a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (!delay_wr && delay_value == 8'd0) |=> delay_value == 8'd0);

    a_r5_sound_quiet: assert property (@(posedge clk) disable iff (rst)
        (!sound_wr && !sound_on) |=> !sound_on);

    a_r6_load_wins: assert property (@(posedge clk) disable iff (rst)
        delay_wr |=> delay_value == $past(wr_value));

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!delay_wr && !tick) |=> $stable(delay_value));
endmodule

bind dual_countdown dual_countdown_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .delay_wr    (delay_wr),
    .sound_wr    (sound_wr),
    .wr_value    (wr_value),
    .delay_value (delay_value),
    .sound_on    (sound_on),
    .tick        (tick_pulse)
);

// File: tb/dual_countdown_test.sv
module dual_countdown_test;
    localparam int unsigned CLK_HZ  = 3000;
    localparam int unsigned TICK_HZ = 60;
    localparam int unsigned DIV     = CLK_HZ / TICK_HZ;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       delay_wr = 1'b0;
    logic       sound_wr = 1'b0;
    logic [7:0] wr_value = 8'd0;
    logic [7:0] delay_value;
    logic       sound_on;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int unsigned m_cnt = 0;
    logic [7:0]  m_delay = 8'd0;
    logic [7:0]  m_sound = 8'd0;

    always #10 clk = ~clk;

    dual_countdown #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) uut (
        .clk(clk), .rst(rst), .delay_wr(delay_wr), .sound_wr(sound_wr),
        .wr_value(wr_value), .delay_value(delay_value), .sound_on(sound_on)
    );

    function automatic logic [7:0] next_val(input logic [7:0] cur, input bit ld,
                                            input logic [7:0] v, input bit tk);
        if (ld)                return v;
        if (tk && cur != 8'd0) return cur - 8'd1;
        return cur;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= 0; m_delay <= 8'd0; m_sound <= 8'd0;
        end else begin
            m_cnt   <= (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
            m_delay <= next_val(m_delay, delay_wr, wr_value, m_cnt == DIV - 1);
            m_sound <= next_val(m_sound, sound_wr, wr_value, m_cnt == DIV - 1);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        delay_wr = 1'b0; sound_wr = 1'b0;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic load(input bit d, input bit s, input logic [7:0] v);
        delay_wr = d; sound_wr = s; wr_value = v;
        step();
        delay_wr = 1'b0; sound_wr = 1'b0;
    endtask

    initial begin
        int gap;
        logic [7:0] prev;
        void'($urandom(32'd20240611));
        @(negedge clk);
        idle(3);
        chk("R1 delay after reset", delay_value, 0);
        chk("R1 sound_on after reset", sound_on, 0);
        rst = 1'b0;

        load(1'b0, 1'b1, 8'd4);
        chk("R7 delay untouched by sound load", delay_value, 0);
        chk("R5 sound_on after load", sound_on, 1);

        load(1'b1, 1'b0, 8'd7);
        chk("R7 sound kept by delay load", sound_on, 1);
        chk("R6 delay loaded", delay_value, 7);
        prev = delay_value;
        while (delay_value == prev) step();
        chk("R3 first decrement", delay_value, int'(prev) - 1);
        prev = delay_value; gap = 0;
        while (delay_value == prev && gap < 4 * DIV) begin step(); gap++; end
        chk("R2 decrement spacing", gap, DIV);
        chk("R3 second decrement", delay_value, int'(prev) - 1);

        while (m_cnt != DIV - 1) step();
        load(1'b1, 1'b0, 8'd9);
        chk("R6 load on tick edge", delay_value, 9);

        idle(5 * DIV);
        chk("R5 sound_on low after countdown", sound_on, 0);

        load(1'b1, 1'b0, 8'd1);
        idle(3 * DIV);
        chk("R4 delay held at zero", delay_value, 0);

        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 16);
            delay_wr = (r == 0);
            sound_wr = (r == 1) || (r == 2 && ($urandom % 2 == 0));
            case ($urandom % 4)
                0:       wr_value = 8'd0;
                1:       wr_value = 8'd1;
                2:       wr_value = 8'd255;
                default: wr_value = 8'($urandom % 8);
            endcase
            step();
            chk("R3 delay vs model", delay_value, m_delay);
            chk("R5 sound_on vs model", sound_on, m_sound != 8'd0);
        end
        idle(2);

        rst = 1'b1;
        load(1'b1, 1'b1, 8'd200);
        rst = 1'b0;
        chk("R1 reset beats load delay", delay_value, 0);
        chk("R1 reset beats load sound", sound_on, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule